// File: doc/BRIEF.md
# Time-Multiplexed Matched FIR Filter

This block is the per-channel matched filter of a sampled-detector trigger path. One new 10-bit sample arrives every four logic clocks, because the logic clock runs four times faster than the filter's sample rate. The block convolves the eight most recent samples with eight programmable signed coefficients. It folds that eight-tap convolution onto two multiply-accumulate lanes. Each lane computes four products in sequence during one sample period, and the two partial sums are then added. Each result comes out after a fixed latency that does not depend on the data.

A registered input selector sits in front of the filter. It feeds either the live converter sample or a word from a small preloaded pattern memory, so the filter can be exercised with a known stream. Coefficients and pattern words are written through simple write-enable ports. The downstream peak finder uses the result on the cycle it is flagged valid.

Top module: `mfir_top`

## Requirements
- R1: After reset, `filtValid` is 0, `filtOut` is 0, every coefficient is 0, the sample history holds zeros and the pattern read pointer is 0.
- R2: For each accepted sample x[n], `filtOut` equals the sum over k = 0..7 of coef[k]·x[n−k]. Samples are unsigned 10-bit values, coefficients are 8-bit two's complement, and `filtOut` is a 24-bit two's complement number. History positions not yet filled since reset count as zero.
- R3: If `sampleStrobe` is high at rising edge n, `filtValid` is high in the cycle that follows edge n+9. The result therefore appears on the tenth edge counted from the capture edge.
- R4: `filtValid` is high for exactly one cycle per accepted sample, provided strobes are at least four cycles apart.
- R5: `filtOut` keeps its value in every cycle in which `filtValid` is low.
- R6: When `testMode` is high at a strobe edge, the sample taken is pattern word [pointer] and `sampleIn` is ignored. The pointer then advances and wraps from 15 to 0. It does not move on strobes taken with `testMode` low. A pulse on `patWrEn` stores `patWrData` at index `patWrIdx`.
- R7: A pulse on `coefWrEn` loads `coefWrData` into tap `coefWrIdx`. Tap 0 weights the newest sample and tap 7 weights the oldest.
- R8: Full-scale inputs do not overflow. Eight samples of 1023 give −1047552 with all coefficients at −128 and +1039368 with all coefficients at +127.
- R9: Strobes spaced exactly four cycles apart give one correct result per sample with no loss. Wider spacings give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | One-cycle pulse marking a new sample |
| sampleIn | input | 10 | Live unsigned sample |
| testMode | input | 1 | Take the sample from the pattern memory instead of `sampleIn` |
| coefWrEn | input | 1 | Coefficient write enable |
| coefWrIdx | input | 3 | Tap index to write |
| coefWrData | input | 8 | Signed coefficient value |
| patWrEn | input | 1 | Pattern memory write enable |
| patWrIdx | input | 4 | Pattern word index |
| patWrData | input | 10 | Pattern word value |
| filtOut | output | 24 | Signed filter result, held between updates |
| filtValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due on the tenth edge after the edge that captures its strobe. The bench's behavioural model computes each convolution when it sees the strobe and pushes the value into a ten-deep expected pipeline, which shifts on every rising edge. On every falling edge, the bench compares the pipeline's last slot and the most recently released value with `filtValid` and `filtOut`. Timing, pulse width and hold behaviour are therefore checked in every cycle, and the arithmetic is checked at the single cycle where it becomes visible. Coefficients change only while no result is in flight, so the model never has to guess which coefficient value a product used.

// File: rtl/mfir_pkg.sv
package mfir_pkg;
  // Folding of the convolution: two lanes, four products each per sample period.
  localparam int NUM_LANES     = 2;
  localparam int TAPS_PER_LANE = 4;
  localparam int NUM_TAPS      = NUM_LANES * TAPS_PER_LANE;
  localparam int SEL_W         = $clog2(TAPS_PER_LANE);
  localparam int LANE_IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int TAP_IDX_W     = $clog2(NUM_TAPS);

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic             capEn;    // capture selected sample into the input register
    logic             shiftEn;  // push captured sample into the history
    logic             prodEn;   // register one product per lane
    logic [SEL_W-1:0] tapSel;   // tap within each lane for this product
    logic             accEn;    // fold registered product into accumulator
    logic             accLoad;  // first product of a sample period: load, not add
    logic             holdEn;   // latch finished partial sums
    logic             sumEn;    // add the partial sums
    logic             outEn;    // publish result and valid strobe
  } mfir_ctrl_t;
endpackage

// File: rtl/mfir_ctrl.sv
module mfir_ctrl
  import mfir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStrobe,
  output mfir_ctrl_t ctrl
);
  localparam logic [SEL_W-1:0] LAST_PH = SEL_W'(TAPS_PER_LANE - 1);

  logic             strobeQ, busy, prodV, lastAcc, holdV, sumV;
  logic [SEL_W-1:0] phase, prodPh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= 1'b0;
      busy    <= 1'b0;
      phase   <= '0;
      prodV   <= 1'b0;
      prodPh  <= '0;
      lastAcc <= 1'b0;
      holdV   <= 1'b0;
      sumV    <= 1'b0;
    end else begin
      strobeQ <= sampleStrobe;
      if (strobeQ) begin
        busy  <= 1'b1;
        phase <= '0;
      end else if (busy) begin
        if (phase == LAST_PH) busy <= 1'b0;
        phase <= phase + 1'b1;
      end
      prodV   <= busy;
      prodPh  <= phase;
      lastAcc <= prodV && (prodPh == LAST_PH);
      holdV   <= lastAcc;
      sumV    <= holdV;
    end
  end

  always_comb begin
    ctrl.capEn   = sampleStrobe;
    ctrl.shiftEn = strobeQ;
    ctrl.prodEn  = busy;
    ctrl.tapSel  = phase;
    ctrl.accEn   = prodV;
    ctrl.accLoad = (prodPh == '0);
    ctrl.holdEn  = lastAcc;
    ctrl.sumEn   = holdV;
    ctrl.outEn   = sumV;
  end
endmodule

// File: rtl/mfir_lane.sv
module mfir_lane #(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     prodEn,
  input  logic                     accEn,
  input  logic                     accLoad,
  input  logic [SAMPLE_W-1:0]      sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int PROD_W = SAMPLE_W + 1 + COEF_W;

  logic signed [PROD_W-1:0] sExt, cExt, prodQ;
  logic signed [ACC_W-1:0]  prodWide;

  always_comb begin
    sExt     = {{(PROD_W - SAMPLE_W){1'b0}}, sample};
    cExt     = {{(PROD_W - COEF_W){coef[COEF_W-1]}}, coef};
    prodWide = {{(ACC_W - PROD_W){prodQ[PROD_W-1]}}, prodQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
      acc   <= '0;
    end else begin
      if (prodEn) prodQ <= sExt * cExt;
      if (accEn)  acc   <= accLoad ? prodWide : acc + prodWide;
    end
  end
endmodule

// File: rtl/mfir_datapath.sv
module mfir_datapath
  import mfir_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 8,
  parameter int ACC_W     = 24,
  parameter int PAT_DEPTH = 16,
  localparam int PAT_IDX_W = $clog2(PAT_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mfir_ctrl_t            ctrl,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  testMode,
  input  logic                  coefWrEn,
  input  logic [TAP_IDX_W-1:0]  coefWrIdx,
  input  logic [COEF_W-1:0]     coefWrData,
  input  logic                  patWrEn,
  input  logic [PAT_IDX_W-1:0]  patWrIdx,
  input  logic [SAMPLE_W-1:0]   patWrData,
  output logic [ACC_W-1:0]      filtOut,
  output logic                  filtValid
);
  localparam logic [PAT_IDX_W-1:0] PAT_LAST = PAT_IDX_W'(PAT_DEPTH - 1);

  logic [SAMPLE_W-1:0]      patMem [PAT_DEPTH];
  logic [PAT_IDX_W-1:0]     patPtr;
  logic [SAMPLE_W-1:0]      muxQ;
  logic [SAMPLE_W-1:0]      hist   [NUM_TAPS];
  logic signed [COEF_W-1:0] coefReg[NUM_TAPS];
  logic signed [ACC_W-1:0]  laneAcc[NUM_LANES];
  logic signed [ACC_W-1:0]  hold   [NUM_LANES];
  logic signed [ACC_W-1:0]  sumC, sumQ;

  // Input selector stage: live sample or pattern word, one register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxQ   <= '0;
      patPtr <= '0;
    end else if (ctrl.capEn) begin
      if (testMode) begin
        muxQ   <= patMem[patPtr];
        patPtr <= (patPtr == PAT_LAST) ? '0 : patPtr + 1'b1;
      end else begin
        muxQ <= sampleIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (patWrEn) patMem[patWrIdx] <= patWrData;
  end

  // Coefficient registers and sample history (index 0 = newest).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TAPS; t++) begin
        coefReg[t] <= '0;
        hist[t]    <= '0;
      end
    end else begin
      if (coefWrEn) coefReg[coefWrIdx] <= coefWrData;
      if (ctrl.shiftEn) begin
        hist[0] <= muxQ;
        for (int t = 1; t < NUM_TAPS; t++) hist[t] <= hist[t-1];
      end
    end
  end

  // One multiply-accumulate lane per group of taps.
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [TAP_IDX_W-1:0] tapIdx;
    assign tapIdx = {LANE_IDX_W'(l), ctrl.tapSel};

    mfir_lane #(
      .SAMPLE_W(SAMPLE_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W)
    ) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .prodEn (ctrl.prodEn),
      .accEn  (ctrl.accEn),
      .accLoad(ctrl.accLoad),
      .sample (hist[tapIdx]),
      .coef   (coefReg[tapIdx]),
      .acc    (laneAcc[l])
    );
  end

  always_comb begin
    sumC = '0;
    for (int l = 0; l < NUM_LANES; l++) sumC = sumC + hold[l];
  end

  // Partial-sum hold, combine and output registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LANES; l++) hold[l] <= '0;
      sumQ      <= '0;
      filtOut   <= '0;
      filtValid <= 1'b0;
    end else begin
      if (ctrl.holdEn)
        for (int l = 0; l < NUM_LANES; l++) hold[l] <= laneAcc[l];
      if (ctrl.sumEn) sumQ <= sumC;
      if (ctrl.outEn) filtOut <= sumQ;
      filtValid <= ctrl.outEn;
    end
  end
endmodule

// File: rtl/mfir_top.sv
module mfir_top
  import mfir_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 8,
  parameter int ACC_W     = 24,
  parameter int PAT_DEPTH = 16,
  localparam int PAT_IDX_W = $clog2(PAT_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleStrobe,
  input  logic [SAMPLE_W-1:0]  sampleIn,
  input  logic                 testMode,
  input  logic                 coefWrEn,
  input  logic [TAP_IDX_W-1:0] coefWrIdx,
  input  logic [COEF_W-1:0]    coefWrData,
  input  logic                 patWrEn,
  input  logic [PAT_IDX_W-1:0] patWrIdx,
  input  logic [SAMPLE_W-1:0]  patWrData,
  output logic [ACC_W-1:0]     filtOut,
  output logic                 filtValid
);
  mfir_ctrl_t ctrl;

  mfir_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleStrobe(sampleStrobe),
    .ctrl        (ctrl)
  );

  mfir_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .ACC_W    (ACC_W),
    .PAT_DEPTH(PAT_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .sampleIn  (sampleIn),
    .testMode  (testMode),
    .coefWrEn  (coefWrEn),
    .coefWrIdx (coefWrIdx),
    .coefWrData(coefWrData),
    .patWrEn   (patWrEn),
    .patWrIdx  (patWrIdx),
    .patWrData (patWrData),
    .filtOut   (filtOut),
    .filtValid (filtValid)
  );
endmodule

// File: rtl/mfir_checker.sv
module mfir_checker #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStrobe,
  input logic             filtValid,
  input logic [ACC_W-1:0] filtOut
);
  // Cycles since reset, saturating; gates the ten-cycle lookback.
  logic [3:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 4'hF) sinceRst <= sinceRst + 1'b1;
  end

  // R3: a captured strobe produces a result ten edges later
  a_r3_latency_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'd10 && $past(sampleStrobe, 10)) |-> filtValid);

  // R3: no result without a strobe ten edges earlier
  a_r3_latency_back: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'd10 && filtValid) |-> $past(sampleStrobe, 10));

  // R4: valid is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    filtValid |=> !filtValid);

  // R5: result is held while valid is low
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 4'd0 && !filtValid) |-> $stable(filtOut));
endmodule

bind mfir_top mfir_checker #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleStrobe(sampleStrobe),
  .filtValid   (filtValid),
  .filtOut     (filtOut)
);

// File: tb/mfir_top_tb.sv
`timescale 1ns/1ps
module mfir_top_tb;
  localparam int LAT = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic        testMode = 1'b0;
  logic        coefWrEn = 1'b0;
  logic [2:0]  coefWrIdx = '0;
  logic [7:0]  coefWrData = '0;
  logic        patWrEn = 1'b0;
  logic [3:0]  patWrIdx = '0;
  logic [9:0]  patWrData = '0;
  logic [23:0] filtOut;
  logic        filtValid;

  always #5 clk = ~clk;

  mfir_top u_dut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
    .testMode(testMode), .coefWrEn(coefWrEn), .coefWrIdx(coefWrIdx),
    .coefWrData(coefWrData), .patWrEn(patWrEn), .patWrIdx(patWrIdx),
    .patWrData(patWrData), .filtOut(filtOut), .filtValid(filtValid)
  );

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  string curTag = "R1";

  // Behavioural reference model
  int hist[8];
  int coefM[8];
  int patM[16];
  int patPtrM;
  bit pipeV[LAT];
  int pipeVal[LAT];
  int heldExp;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin hist[i] = 0; coefM[i] = 0; end
      for (int i = 0; i < LAT; i++) begin pipeV[i] = 0; pipeVal[i] = 0; end
      patPtrM = 0;
      heldExp = 0;
    end else begin
      for (int i = LAT - 1; i > 0; i--) begin
        pipeV[i]   = pipeV[i-1];
        pipeVal[i] = pipeVal[i-1];
      end
      pipeV[0] = 0;
      if (sampleStrobe) begin
        int x;
        int s;
        if (testMode) begin
          x = patM[patPtrM];
          patPtrM = (patPtrM + 1) % 16;
        end else x = int'(sampleIn);
        for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        s = 0;
        for (int i = 0; i < 8; i++) s += coefM[i] * hist[i];
        pipeV[0]   = 1;
        pipeVal[0] = s;
      end
      if (pipeV[LAT-1]) heldExp = pipeVal[LAT-1];
      if (coefWrEn) coefM[coefWrIdx] = int'($signed(coefWrData));
      if (patWrEn)  patM[patWrIdx]   = int'(patWrData);
    end
  end

  task automatic check(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Compared on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3,R4 valid", int'(filtValid), int'(pipeV[LAT-1]));
      check({curTag, " value"}, int'($signed(filtOut)), heldExp);
    end
  end

  task automatic cyc();
    @(negedge clk);
    sampleStrobe = 0; coefWrEn = 0; patWrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  task automatic sendSample(int val, bit tm, int gap);
    @(negedge clk);
    sampleStrobe = 1; sampleIn = 10'(val); testMode = tm;
    coefWrEn = 0; patWrEn = 0;
    repeat (gap - 1) cyc();
  endtask

  task automatic writeCoef(int idx, int val);
    @(negedge clk);
    sampleStrobe = 0; coefWrEn = 1; coefWrIdx = 3'(idx); coefWrData = 8'(val);
  endtask

  task automatic writePat(int idx, int val);
    @(negedge clk);
    sampleStrobe = 0; patWrEn = 1; patWrIdx = 4'(idx); patWrData = 10'(val);
  endtask

  task automatic setCoefs(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
    writeCoef(0, c0); writeCoef(1, c1); writeCoef(2, c2); writeCoef(3, c3);
    writeCoef(4, c4); writeCoef(5, c5); writeCoef(6, c6); writeCoef(7, c7);
    cyc();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 valid", int'(filtValid), 0);
    check("R1 out", int'(filtOut), 0);

    // R1: zero coefficients after reset give zero output
    curTag = "R1";
    sendSample(500, 0, 4);
    idle(12);

    // R2, R7, R9: mixed-sign coefficients, back-to-back samples
    curTag = "R2";
    setCoefs(3, -5, 7, 20, -9, 1, 0, -2);
    curTag = "R9";
    for (int i = 0; i < 14; i++) sendSample((i * 173 + 41) % 1024, 0, 4);
    idle(12);

    // R3: wider spacing between strobes
    curTag = "R3";
    for (int i = 0; i < 6; i++) sendSample((i * 311 + 7) % 1024, 0, 4 + i);
    idle(12);

    // R7: tap ordering, single nonzero coefficient on tap 5
    curTag = "R7";
    setCoefs(0, 0, 0, 0, 0, 1, 0, 0);
    sendSample(100, 0, 4);
    for (int i = 0; i < 8; i++) sendSample(0, 0, 4);
    idle(12);

    // R8: full-scale negative and positive extremes
    curTag = "R8";
    setCoefs(-128, -128, -128, -128, -128, -128, -128, -128);
    for (int i = 0; i < 8; i++) sendSample(1023, 0, 4);
    idle(12);
    check("R8 negative extreme", int'($signed(filtOut)), -1047552);
    setCoefs(127, 127, 127, 127, 127, 127, 127, 127);
    for (int i = 0; i < 8; i++) sendSample(1023, 0, 4);
    idle(12);
    check("R8 positive extreme", int'($signed(filtOut)), 1039368);

    // R6: pattern memory path, live input ignored, pointer wraps
    curTag = "R6";
    setCoefs(1, 2, -3, 4, -1, 5, 2, -7);
    for (int i = 0; i < 16; i++) writePat(i, (i * 37 + 5) % 1024);
    cyc();
    for (int i = 0; i < 20; i++) sendSample(999, 1, 4);
    sendSample(321, 0, 4);          // live sample, pointer must not move
    for (int i = 0; i < 3; i++) sendSample(888, 1, 4);
    idle(14);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule